// File: doc/BRIEF.md
# Periodic Interrupt Timer with Priority Arbitration

This block is a programmable down-counting timer that produces a periodic, prioritised and vectored interrupt request. Software sets an 8-bit reload modulus and a one-bit slow-clock select through one write port. Through the same port it also sets a 3-bit request level and an 8-bit vector. The counter advances on the system clock divided by four, and by a further 512 when the slow select is set. Each time it reaches terminal count it reloads the modulus and marks an interrupt as pending. One period therefore lasts modulus × prescale factor × 4 clock cycles.

The pending timer request is arbitrated against a single external request level. When both sides ask at the same level, the timer is preferred. The winning level is shown to the core only if it is above the core's current mask, and level 7 is shown whatever the mask is. When the core acknowledges a level, the block answers one cycle later. It either returns its vector with a valid strobe and drops its pending flag, or it passes the acknowledge on to the external source.

A request level of 000 turns the interrupt off, but the counter keeps running. Only a modulus of zero halts the counter. The block has no stop input, so a low-power stop of the core has no effect on it.

Top module: `pit_irq_unit`

## Requirements
- R1: After reset, irq_level reads 0, vec_valid, ext_ack and tc_pulse read 0, vec_data reads 0x0F and the timer is halted (modulus 0, request level 0).
- R2: A write with wr_sel=0 loads the modulus from wr_data[7:0] and the slow select from wr_data[8], and it restarts the dividers. With the slow select at 0 and modulus M>0, tc_pulse is high for one cycle 4·M cycles after the write edge, and again every 4·M cycles after that.
- R3: With the slow select at 1, the period is 2048·M cycles.
- R4: While the modulus is 0, tc_pulse never goes high. Writing 0 to a running timer stops it.
- R5: A write with wr_sel=1 loads the vector from wr_data[7:0] and the level from wr_data[10:8]. At level 000, irq_level stays 0 while tc_pulse keeps recurring. The pending flag is still set, so raising the level later presents it in the cycle after the write.
- R6: The winning level appears on irq_level only when it is greater than cpu_mask, or when it equals 7. Otherwise irq_level is 0.
- R7: A pending timer request at level L beats an external request at level L or below, and irq_src_timer is then 1. A higher external level wins, and irq_src_timer is then 0.
- R8: An iack with iack_level equal to the timer's winning level gives vec_valid=1 with vec_data equal to the programmed vector in the following cycle. It also clears the pending flag, and a tie at that level is answered by the timer.
- R9: An iack at the external level while the timer does not win gives ext_ack=1 in the following cycle, with vec_valid 0 and the timer's pending flag left unchanged.
- R10: An iack at a level that matches neither source produces neither vec_valid nor ext_ack and leaves the pending request in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: modulus and slow select, 1: vector and level |
| wr_data | input | 11 | Write data |
| cpu_mask | input | 3 | Current interrupt mask of the core |
| ext_level | input | 3 | External request level, 0 is none |
| iack | input | 1 | Acknowledge strobe from the core |
| iack_level | input | 3 | Level being acknowledged |
| irq_level | output | 3 | Level presented to the core, 0 is none |
| irq_src_timer | output | 1 | The presented request is the timer's |
| vec_valid | output | 1 | Vector returned for an acknowledge |
| vec_data | output | 8 | Programmed vector |
| ext_ack | output | 1 | Acknowledge passed to the external source |
| tc_pulse | output | 1 | One-cycle pulse at terminal count |

## Verification
The arbitration outputs irq_level and irq_src_timer are combinational in the level registers, the pending flag, cpu_mask and ext_level. The bench checks them a fraction of a cycle after changing a mask or external level, and at the first falling edge after a register write. Acknowledge answers (vec_valid, ext_ack) and the pending clear take effect one edge after the iack edge, so they are sampled at the next falling edge. A terminal count lands exactly 4·M·prescale edges after the write edge. Each period check therefore tests that tc_pulse is low one edge early and high on the expected edge.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_NMI = '1;

  typedef enum logic {
    SEL_TIMER = 1'b0,
    SEL_CTRL  = 1'b1
  } regsel_e;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int unsigned BASE_DIV = 4,
  parameter int unsigned PRE_DIV  = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic slow_sel,
  output logic tick
);
  localparam int unsigned BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

  logic [BW-1:0] base_q;
  logic          base_tick;
  logic          slow_tick;

  assign base_tick = (base_q == BW'(BASE_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         base_q <= '0;
    else if (clear)     base_q <= '0;
    else if (base_tick) base_q <= '0;
    else                base_q <= base_q + 1'b1;
  end

  generate
    if (PRE_DIV > 1) begin : g_pre
      logic [PW-1:0] pre_q;
      logic          pre_last;
      assign pre_last = (pre_q == PW'(PRE_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         pre_q <= '0;
        else if (clear)     pre_q <= '0;
        else if (base_tick) pre_q <= pre_last ? '0 : pre_q + 1'b1;
      end
      assign slow_tick = base_tick && pre_last;
    end else begin : g_nopre
      assign slow_tick = base_tick;
    end
  endgenerate

  assign tick = !clear && (slow_sel ? slow_tick : base_tick);
endmodule

// File: rtl/pit_downcount.sv
module pit_downcount #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic [CNT_W-1:0] modulus,
  output logic             tc
);
  logic [CNT_W-1:0] cnt_q;

  assign tc = tick && !load && (modulus != '0) && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (tc)                    cnt_q <= modulus;
    else if (tick && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/pit_arbiter.sv
module pit_arbiter
  import pit_pkg::*;
(
  input  lvl_t t_lvl,
  input  lvl_t ext_level,
  input  lvl_t cpu_mask,
  input  logic iack,
  input  lvl_t iack_level,
  output lvl_t irq_level,
  output logic irq_src_timer,
  output logic ack_timer,
  output logic ack_ext
);
  logic timer_wins;
  lvl_t win_lvl;
  logic shown;

  always_comb begin
    timer_wins    = (t_lvl != '0) && (t_lvl >= ext_level);
    win_lvl       = timer_wins ? t_lvl : ext_level;
    shown         = (win_lvl != '0) && ((win_lvl > cpu_mask) || (win_lvl == LVL_NMI));
    irq_level     = shown ? win_lvl : '0;
    irq_src_timer = shown && timer_wins;
    ack_timer     = iack && timer_wins && (iack_level == t_lvl);
    ack_ext       = iack && !ack_timer && (ext_level != '0) && (iack_level == ext_level);
  end
endmodule

// File: rtl/pit_irq_unit.sv
module pit_irq_unit
  import pit_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned BASE_DIV = 4,
  parameter int unsigned PRE_DIV  = 512,
  parameter logic [VEC_W-1:0] VEC_RST = 8'h0F,
  localparam int unsigned DW = VEC_W + LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [LVL_W-1:0] cpu_mask,
  input  logic [LVL_W-1:0] ext_level,
  input  logic             iack,
  input  logic [LVL_W-1:0] iack_level,
  output logic [LVL_W-1:0] irq_level,
  output logic             irq_src_timer,
  output logic             vec_valid,
  output logic [VEC_W-1:0] vec_data,
  output logic             ext_ack,
  output logic             tc_pulse
);
  logic [CNT_W-1:0] mod_q;
  logic             slow_q;
  logic [VEC_W-1:0] vec_q;
  lvl_t             lvl_q;
  logic             pend_q;

  logic wr_timer, wr_ctrl;
  logic tick, tc;
  lvl_t t_lvl;
  logic ack_timer, ack_ext;

  assign wr_timer = wr_en && (regsel_e'(wr_sel) == SEL_TIMER);
  assign wr_ctrl  = wr_en && (regsel_e'(wr_sel) == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q  <= '0;
      slow_q <= 1'b0;
      vec_q  <= VEC_RST;
      lvl_q  <= '0;
    end else begin
      if (wr_timer) begin
        mod_q  <= wr_data[CNT_W-1:0];
        slow_q <= wr_data[CNT_W];
      end
      if (wr_ctrl) begin
        vec_q <= wr_data[VEC_W-1:0];
        lvl_q <= wr_data[DW-1:VEC_W];
      end
    end
  end

  pit_prescaler #(.BASE_DIV(BASE_DIV), .PRE_DIV(PRE_DIV)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (wr_timer),
    .slow_sel (slow_q),
    .tick     (tick)
  );

  pit_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_timer),
    .load_val (wr_data[CNT_W-1:0]),
    .tick     (tick),
    .modulus  (mod_q),
    .tc       (tc)
  );

  assign t_lvl = pend_q ? lvl_q : '0;

  pit_arbiter u_arb (
    .t_lvl         (t_lvl),
    .ext_level     (ext_level),
    .cpu_mask      (cpu_mask),
    .iack          (iack),
    .iack_level    (iack_level),
    .irq_level     (irq_level),
    .irq_src_timer (irq_src_timer),
    .ack_timer     (ack_timer),
    .ack_ext       (ack_ext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      tc_pulse  <= 1'b0;
      vec_valid <= 1'b0;
      ext_ack   <= 1'b0;
    end else begin
      if (tc)             pend_q <= 1'b1;
      else if (ack_timer) pend_q <= 1'b0;
      tc_pulse  <= tc;
      vec_valid <= ack_timer;
      ext_ack   <= ack_ext;
    end
  end

  assign vec_data = vec_q;
endmodule

// File: rtl/pit_irq_unit_chk.sv
module pit_irq_unit_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iack,
  input logic [2:0]       iack_level,
  input logic [2:0]       ext_level,
  input logic [2:0]       cpu_mask,
  input logic [2:0]       irq_level,
  input logic             irq_src_timer,
  input logic             vec_valid,
  input logic             ext_ack,
  input logic             tc_pulse,
  input logic [CNT_W-1:0] mod_q
);
  p_tc_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse);

  p_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_q == '0) |=> !tc_pulse);

  p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 3'd0) |-> ((irq_level > cpu_mask) || (irq_level == 3'd7)));

  p_tie_timer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_src_timer |-> (irq_level >= ext_level));

  p_ext_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 3'd0 && !irq_src_timer) |-> (irq_level == ext_level));

  p_ack_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && irq_src_timer && iack_level == irq_level) |=> vec_valid);

  p_ack_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && irq_level != 3'd0 && !irq_src_timer && iack_level == irq_level) |=> ext_ack);

  p_one_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid && ext_ack));
endmodule

bind pit_irq_unit pit_irq_unit_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/pit_irq_unit_test.sv
`timescale 1ns/1ps
module pit_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [10:0] wr_data = '0;
  logic [2:0]  cpu_mask = '0;
  logic [2:0]  ext_level = '0;
  logic        iack = 1'b0;
  logic [2:0]  iack_level = '0;
  logic [2:0]  irq_level;
  logic        irq_src_timer;
  logic        vec_valid;
  logic [7:0]  vec_data;
  logic        ext_ack;
  logic        tc_pulse;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pit_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cpu_mask(cpu_mask), .ext_level(ext_level), .iack(iack), .iack_level(iack_level),
    .irq_level(irq_level), .irq_src_timer(irq_src_timer), .vec_valid(vec_valid),
    .vec_data(vec_data), .ext_ack(ext_ack), .tc_pulse(tc_pulse)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cpu_mask = '0; ext_level = '0; iack = 1'b0; wr_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input bit sel, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = 11'(data);
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic ack(input int lvl);
    @(negedge clk);
    iack = 1'b1; iack_level = 3'(lvl);
    @(posedge clk);
    #1 iack = 1'b0;
  endtask

  // Called just after a reference edge; terminal count is due n edges later.
  task automatic expect_tc(input int n, input string tag);
    repeat (n - 1) @(posedge clk);
    @(negedge clk);
    chk(tc_pulse == 1'b0, {tag, " early"}, tc_pulse, 0);
    @(posedge clk);
    @(negedge clk);
    chk(tc_pulse == 1'b1, {tag, " due"}, tc_pulse, 1);
  endtask

  // Level, vector, modulus 1; leaves the flag pending and the counter halted.
  task automatic arm(input int lvl, input int vec);
    wr(1'b1, (lvl << 8) | vec);
    wr(1'b0, 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    wr(1'b0, 0);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk(irq_level == 0, "R1 irq_level", irq_level, 0);
    chk(!vec_valid && !ext_ack && !tc_pulse, "R1 strobes", {vec_valid, ext_ack, tc_pulse}, 0);
    chk(vec_data == 8'h0F, "R1 vec_data", vec_data, 8'h0F);
    repeat (40) @(negedge clk);
    chk(!tc_pulse && irq_level == 0, "R1 halted", tc_pulse, 0);
  endtask

  task automatic t_period();
    do_reset();
    wr(1'b0, 3);
    expect_tc(12, "R2 first");
    expect_tc(12, "R2 second");
    wr(1'b0, 5);
    expect_tc(20, "R2 reload");
  endtask

  task automatic t_prescale();
    do_reset();
    wr(1'b0, (1 << 8) | 2);
    expect_tc(4096, "R3 slow");
  endtask

  task automatic t_halt();
    bit seen = 1'b0;
    do_reset();
    wr(1'b0, 0);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tc_pulse) seen = 1'b1;
    end
    chk(!seen, "R4 zero modulus", seen, 0);
    wr(1'b0, 6);
    repeat (10) @(posedge clk);
    wr(1'b0, 0);
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (tc_pulse) seen = 1'b1;
    end
    chk(!seen, "R4 stop running", seen, 0);
  endtask

  task automatic t_disabled();
    do_reset();
    wr(1'b1, 8'h33);
    wr(1'b0, 2);
    expect_tc(8, "R5 runs while off");
    chk(irq_level == 0, "R5 not shown", irq_level, 0);
    expect_tc(8, "R5 keeps running");
    chk(irq_level == 0, "R5 still not shown", irq_level, 0);
    wr(1'b1, (3 << 8) | 8'h33);
    @(negedge clk);
    chk(irq_level == 3, "R5 shown after enable", irq_level, 3);
  endtask

  task automatic t_mask();
    do_reset();
    arm(4, 8'h40);
    @(negedge clk);
    cpu_mask = 3'd3; #1;
    chk(irq_level == 4, "R6 above mask", irq_level, 4);
    cpu_mask = 3'd4; #1;
    chk(irq_level == 0, "R6 equal mask", irq_level, 0);
    cpu_mask = 3'd6; #1;
    chk(irq_level == 0, "R6 below mask", irq_level, 0);
    wr(1'b1, (7 << 8) | 8'h40);
    cpu_mask = 3'd7;
    @(negedge clk);
    chk(irq_level == 7, "R6 level 7 always", irq_level, 7);
  endtask

  task automatic t_tie();
    do_reset();
    arm(5, 8'h5A);
    @(negedge clk);
    ext_level = 3'd5; #1;
    chk(irq_level == 5 && irq_src_timer, "R7 tie timer", {irq_level, irq_src_timer}, {3'd5, 1'b1});
    ext_level = 3'd6; #1;
    chk(irq_level == 6 && !irq_src_timer, "R7 higher ext", {irq_level, irq_src_timer}, {3'd6, 1'b0});
    ext_level = 3'd2; #1;
    chk(irq_level == 5 && irq_src_timer, "R7 lower ext", {irq_level, irq_src_timer}, {3'd5, 1'b1});
    ext_level = 3'd5;
    ack(5);
    @(negedge clk);
    chk(vec_valid && !ext_ack, "R8 tie ack to timer", {vec_valid, ext_ack}, 2'b10);
    chk(irq_level == 5 && !irq_src_timer, "R8 ext left after clear", {irq_level, irq_src_timer}, {3'd5, 1'b0});
  endtask

  task automatic t_ack();
    do_reset();
    arm(2, 8'hA5);
    ack(3);
    @(negedge clk);
    chk(!vec_valid && !ext_ack, "R10 mismatch ignored", {vec_valid, ext_ack}, 0);
    chk(irq_level == 2, "R10 pending kept", irq_level, 2);
    ack(2);
    @(negedge clk);
    chk(vec_valid && vec_data == 8'hA5, "R8 vector", vec_data, 8'hA5);
    chk(irq_level == 0, "R8 pending cleared", irq_level, 0);
    @(negedge clk);
    chk(!vec_valid, "R8 single strobe", vec_valid, 0);
  endtask

  task automatic t_ext_ack();
    do_reset();
    arm(3, 8'h77);
    @(negedge clk);
    ext_level = 3'd6;
    ack(6);
    @(negedge clk);
    chk(ext_ack && !vec_valid, "R9 ext ack", {ext_ack, vec_valid}, 2'b10);
    ext_level = 3'd0; #1;
    chk(irq_level == 3 && irq_src_timer, "R9 timer still pending", irq_level, 3);
  endtask

  initial begin
    t_reset();
    t_period();
    t_prescale();
    t_halt();
    t_disabled();
    t_mask();
    t_tie();
    t_ack();
    t_ext_ack();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    checks++;
    errors++;
    $display("FAIL R2 watchdog: actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule